// File: doc/BRIEF.md
# Ping-Pong ECC Chunk Transfer Engine

This engine moves one flash page into a pair of alternating on-chip buffers. The page is split into ECC steps of `CHUNK_BYTES` bytes each, and step k fills buffer k mod 2. Once a step's last byte is stored, the engine waits for the external BCH decoder to report that step. It then hands the filled buffer to the consumer and starts filling the other buffer straight away. One buffer can therefore be drained while the next step streams in.

The decoder is outside this block; its per-step status word is an input. The engine keeps a running maximum of the corrected-bit counts and a sticky uncorrectable marker, and reports one page result at the end. A consumer keeps ownership of a buffer from its ready pulse until it pulses the matching release bit. While the buffer about to be filled is still owned, the flash stream is stalled through `flashReady`. A per-step wait limit on the decoder status aborts a page whose status never arrives.

Top module: `pp_chunk_engine`

## Requirements
- R1: A start pulse accepted while idle latches the step count as `pageBytes / CHUNK_BYTES`, with the remainder dropped. A zero step count gives `donePulse` in the cycle after the start, with `maxFlips` equal to 0.
- R2: Byte j of step k (stream order within the page) is written with `bufSel` = k mod 2, `bufAddr` = j, and `bufData` equal to the flash byte. Exactly one write is made per cycle in which `flashValid` and `flashReady` are both high.
- R3: A buffer is owned by the consumer from its `chunkReady` pulse until the cycle in which its `releaseBuf` bit is high. While the buffer to be filled is owned, `flashReady` stays low and nothing is written to it.
- R4: In the cycle after a non-final step's ECC status is captured, filling of the next step is under way: `flashReady` is high unless the next buffer is owned.
- R5: The status word has the uncorrectable flag at bit 2 and a 7-bit corrected count in bits 9:3; all other bits are ignored. `maxFlips` is the largest count seen in the page.
- R6: Any uncorrectable step forces `maxFlips` to all ones (255) and sets `pageFail`. Both hold until the next accepted start.
- R7: `chunkReady` pulses in the cycle after a step's status is captured, with `chunkBuf` = k mod 2 and `chunkIdx` = k.
- R8: `donePulse` is high for exactly one cycle, the cycle after the final step's status is captured.
- R9: Status is accepted on any of the first `TIMEOUT_CYCLES` cycles after a step's last byte (cycle 0 to `TIMEOUT_CYCLES`-1). If it has not arrived by then, the page is aborted, `pageTimeout` is set and `donePulse` follows in the next cycle.
- R10: `startPulse` while a page is in progress, and `eccValid` while no status is awaited, have no effect.
- R11: After reset, `flashReady`, `bufWe`, `chunkReady`, `donePulse`, `pageFail` and `pageTimeout` are low, and `maxFlips` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Begin a page transfer |
| pageBytes | input | PAGE_W | Page size in bytes, sampled with the start |
| flashData | input | 8 | Byte from the flash data port |
| flashValid | input | 1 | `flashData` is valid |
| flashReady | output | 1 | Engine accepts a byte this cycle |
| eccValid | input | 1 | Decoder status for the current step is valid |
| eccStatus | input | 16 | Decoder status word (bit 2 uncorrectable, bits 9:3 count) |
| bufWe | output | 1 | Buffer write enable |
| bufSel | output | 1 | Buffer being written |
| bufAddr | output | CH_LOG | Byte address within the buffer |
| bufData | output | 8 | Byte written |
| chunkReady | output | 1 | A step's buffer is ready for the consumer |
| chunkBuf | output | 1 | Buffer index of the ready step |
| chunkIdx | output | STEP_W | Step number of the ready step |
| releaseBuf | input | 2 | Consumer returns buffer 0 or 1 |
| donePulse | output | 1 | Page finished or aborted |
| maxFlips | output | 8 | Page result: maximum correction count, or 255 on failure |
| pageFail | output | 1 | Some step of the page was uncorrectable |
| pageTimeout | output | 1 | Page aborted on a missing status |

## Verification
The bench runs every page length from one to eight steps of a small configuration with a slow consumer, so that both buffers are owned at once and the stream must stall. A design that forgot the ownership check would overwrite a buffer still being drained. Status words put ones in the ignored bits. Uncorrectable steps are placed in the middle of a page, where a result that is not sticky would fall back to a plain maximum. The decoder status is given on the last allowed wait cycle and is also left out completely, which catches a wait limit that is off by one. A fake status and a second start are injected during a fill; a design that reacts to either produces a wrong result or a wrong step count.

// File: rtl/pp_chunk_pkg.sv
package pp_chunk_pkg;

  localparam int ECC_STAT_W   = 16;
  localparam int ECC_FAIL_BIT = 2;
  localparam int ECC_CNT_LSB  = 3;
  localparam int ECC_CNT_W    = 7;
  localparam int RES_W        = 8;
  localparam int DATA_W       = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_WAIT,
    ST_DONE
  } engState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic init;
    logic take;
    logic capture;
    logic advance;
    logic tmrRun;
    logic abort;
  } engStrobe_t;

  // conditions reported back by the datapath
  typedef struct packed {
    logic zeroSteps;
    logic lastByte;
    logic lastChunk;
    logic tmrExpired;
    logic curHeld;
  } engStatus_t;

endpackage

// File: rtl/pp_chunk_ctrl.sv
module pp_chunk_ctrl
  import pp_chunk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       flashValid,
  input  logic       eccValid,
  input  engStatus_t stat,
  output engStrobe_t strb,
  output logic       flashReady,
  output logic       donePulse
);

  engState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strb   = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (startPulse) begin
          strb.init = 1'b1;
          stateD    = stat.zeroSteps ? ST_DONE : ST_FILL;
        end
      end
      ST_FILL: begin
        strb.take = flashValid && !stat.curHeld;
        if (strb.take && stat.lastByte) stateD = ST_WAIT;
      end
      ST_WAIT: begin
        if (eccValid) begin
          // status wins over expiry on the final allowed cycle
          strb.capture = 1'b1;
          if (stat.lastChunk) begin
            stateD = ST_DONE;
          end else begin
            strb.advance = 1'b1;
            stateD       = ST_FILL;
          end
        end else if (stat.tmrExpired) begin
          strb.abort = 1'b1;
          stateD     = ST_DONE;
        end else begin
          strb.tmrRun = 1'b1;
        end
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  assign flashReady = (stateQ == ST_FILL) && !stat.curHeld;
  assign donePulse  = (stateQ == ST_DONE);

endmodule

// File: rtl/pp_chunk_dpath.sv
module pp_chunk_dpath
  import pp_chunk_pkg::*;
#(
  parameter int CHUNK_BYTES    = 1024,
  parameter int MAX_PAGE_BYTES = 16384,
  parameter int TIMEOUT_CYCLES = 20000,
  localparam int CH_LOG = $clog2(CHUNK_BYTES),
  localparam int PAGE_W = $clog2(MAX_PAGE_BYTES) + 1,
  localparam int STEP_W = PAGE_W - CH_LOG
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  engStrobe_t            strb,
  input  logic [PAGE_W-1:0]     pageBytes,
  input  logic [DATA_W-1:0]     flashData,
  input  logic [ECC_STAT_W-1:0] eccStatus,
  input  logic [1:0]            releaseBuf,
  output engStatus_t            stat,
  output logic                  bufWe,
  output logic                  bufSel,
  output logic [CH_LOG-1:0]     bufAddr,
  output logic [DATA_W-1:0]     bufData,
  output logic                  chunkReady,
  output logic                  chunkBuf,
  output logic [STEP_W-1:0]     chunkIdx,
  output logic [RES_W-1:0]      maxFlips,
  output logic                  pageFail,
  output logic                  pageTimeout
);

  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);

  logic [STEP_W-1:0]    stepsQ, chunkQ, rdyIdxQ;
  logic [CH_LOG-1:0]    byteQ;
  logic [TMR_W-1:0]     tmrQ;
  logic [ECC_CNT_W-1:0] maxQ;
  logic                 failQ, toQ, rdyQ, rdyBufQ;
  logic [1:0]           heldQ;

  logic [STEP_W-1:0]    pageSteps;
  logic [ECC_CNT_W-1:0] eccCnt;
  logic                 eccFail;
  logic                 unusedBits;

  assign pageSteps  = pageBytes[PAGE_W-1:CH_LOG];
  assign eccCnt     = eccStatus[ECC_CNT_LSB +: ECC_CNT_W];
  assign eccFail    = eccStatus[ECC_FAIL_BIT];
  assign unusedBits = ^{pageBytes[CH_LOG-1:0],
                        eccStatus[ECC_STAT_W-1:ECC_CNT_LSB+ECC_CNT_W],
                        eccStatus[ECC_FAIL_BIT-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepsQ  <= '0;
      chunkQ  <= '0;
      byteQ   <= '0;
      tmrQ    <= '0;
      maxQ    <= '0;
      failQ   <= 1'b0;
      toQ     <= 1'b0;
      rdyQ    <= 1'b0;
      rdyBufQ <= 1'b0;
      rdyIdxQ <= '0;
    end else begin
      rdyQ <= strb.capture;
      tmrQ <= strb.tmrRun ? tmrQ + 1'b1 : '0;
      if (strb.init) begin
        stepsQ <= pageSteps;
        chunkQ <= '0;
        byteQ  <= '0;
        maxQ   <= '0;
        failQ  <= 1'b0;
        toQ    <= 1'b0;
      end
      if (strb.take) byteQ <= byteQ + 1'b1;
      if (strb.capture) begin
        rdyBufQ <= chunkQ[0];
        rdyIdxQ <= chunkQ;
        if (eccFail)            failQ <= 1'b1;
        else if (eccCnt > maxQ) maxQ  <= eccCnt;
      end
      if (strb.advance) chunkQ <= chunkQ + 1'b1;
      if (strb.abort)   toQ    <= 1'b1;
    end
  end

  // ownership flag per ping-pong buffer
  for (genvar g = 0; g < 2; g++) begin : g_hold
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                     heldQ[g] <= 1'b0;
      else if (strb.capture && (chunkQ[0] == 1'(g))) heldQ[g] <= 1'b1;
      else if (releaseBuf[g])                        heldQ[g] <= 1'b0;
    end
  end

  assign stat.zeroSteps  = (pageSteps == '0);
  assign stat.lastByte   = (byteQ == '1);
  assign stat.lastChunk  = (chunkQ == stepsQ - 1'b1);
  assign stat.tmrExpired = (tmrQ == TMR_W'(TIMEOUT_CYCLES - 1));
  assign stat.curHeld    = heldQ[chunkQ[0]];

  assign bufWe       = strb.take;
  assign bufSel      = chunkQ[0];
  assign bufAddr     = byteQ;
  assign bufData     = flashData;
  assign chunkReady  = rdyQ;
  assign chunkBuf    = rdyBufQ;
  assign chunkIdx    = rdyIdxQ;
  assign maxFlips    = failQ ? '1 : RES_W'(maxQ);
  assign pageFail    = failQ;
  assign pageTimeout = toQ;

endmodule

// File: rtl/pp_chunk_engine.sv
module pp_chunk_engine
  import pp_chunk_pkg::*;
#(
  parameter int CHUNK_BYTES    = 1024,
  parameter int MAX_PAGE_BYTES = 16384,
  parameter int TIMEOUT_CYCLES = 20000,
  localparam int CH_LOG = $clog2(CHUNK_BYTES),
  localparam int PAGE_W = $clog2(MAX_PAGE_BYTES) + 1,
  localparam int STEP_W = PAGE_W - CH_LOG
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startPulse,
  input  logic [PAGE_W-1:0]     pageBytes,
  input  logic [DATA_W-1:0]     flashData,
  input  logic                  flashValid,
  output logic                  flashReady,
  input  logic                  eccValid,
  input  logic [ECC_STAT_W-1:0] eccStatus,
  output logic                  bufWe,
  output logic                  bufSel,
  output logic [CH_LOG-1:0]     bufAddr,
  output logic [DATA_W-1:0]     bufData,
  output logic                  chunkReady,
  output logic                  chunkBuf,
  output logic [STEP_W-1:0]     chunkIdx,
  input  logic [1:0]            releaseBuf,
  output logic                  donePulse,
  output logic [RES_W-1:0]      maxFlips,
  output logic                  pageFail,
  output logic                  pageTimeout
);

  engStrobe_t strb;
  engStatus_t stat;

  pp_chunk_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .flashValid (flashValid),
    .eccValid   (eccValid),
    .stat       (stat),
    .strb       (strb),
    .flashReady (flashReady),
    .donePulse  (donePulse)
  );

  pp_chunk_dpath #(
    .CHUNK_BYTES    (CHUNK_BYTES),
    .MAX_PAGE_BYTES (MAX_PAGE_BYTES),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .pageBytes   (pageBytes),
    .flashData   (flashData),
    .eccStatus   (eccStatus),
    .releaseBuf  (releaseBuf),
    .stat        (stat),
    .bufWe       (bufWe),
    .bufSel      (bufSel),
    .bufAddr     (bufAddr),
    .bufData     (bufData),
    .chunkReady  (chunkReady),
    .chunkBuf    (chunkBuf),
    .chunkIdx    (chunkIdx),
    .maxFlips    (maxFlips),
    .pageFail    (pageFail),
    .pageTimeout (pageTimeout)
  );

endmodule

// File: rtl/pp_chunk_engine_chk.sv
module pp_chunk_engine_chk (
  input logic       clk,
  input logic       rstN,
  input logic       startPulse,
  input logic       flashValid,
  input logic       flashReady,
  input logic       eccValid,
  input logic       eccFailBit,
  input logic       bufWe,
  input logic       chunkReady,
  input logic       donePulse,
  input logic [7:0] maxFlips,
  input logic       pageFail,
  input logic       pageTimeout
);

  // R2: a write only happens on a completed handshake
  p_we_handshake_r2: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> (flashValid && flashReady));

  // R7: a ready pulse always follows a status capture
  p_ready_after_ecc_r7: assert property (@(posedge clk) disable iff (!rstN)
    chunkReady |-> $past(eccValid));

  // R6: failure marker only rises after an uncorrectable status
  p_fail_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pageFail) |-> $past(eccValid && eccFailBit));

  // R5: without a new start the page result never decreases
  p_max_nondecreasing_r5: assert property (@(posedge clk) disable iff (!rstN)
    !startPulse |=> (maxFlips >= $past(maxFlips)));

  // R9: abort only happens when no status was offered
  p_timeout_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pageTimeout) |-> !$past(eccValid));

  // R8: no byte is accepted while the completion pulse is out
  p_no_fill_at_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !flashReady);

endmodule

bind pp_chunk_engine pp_chunk_engine_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .startPulse  (startPulse),
  .flashValid  (flashValid),
  .flashReady  (flashReady),
  .eccValid    (eccValid),
  .eccFailBit  (eccStatus[pp_chunk_pkg::ECC_FAIL_BIT]),
  .bufWe       (bufWe),
  .chunkReady  (chunkReady),
  .donePulse   (donePulse),
  .maxFlips    (maxFlips),
  .pageFail    (pageFail),
  .pageTimeout (pageTimeout)
);

// File: tb/tb_pp_chunk_engine.sv
module tb_pp_chunk_engine;

  localparam int CH   = 8;
  localparam int MAXP = 64;
  localparam int TO   = 8;
  localparam int PW   = 7;
  localparam int SW   = 4;
  localparam int CHL  = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic [PW-1:0] pageBytes = '0;
  logic [7:0]    flashData = '0;
  logic          flashValid = 1'b0;
  logic          flashReady;
  logic          eccValid = 1'b0;
  logic [15:0]   eccStatus = '0;
  logic          bufWe, bufSel, chunkReady, chunkBuf, donePulse, pageFail, pageTimeout;
  logic [CHL-1:0] bufAddr;
  logic [7:0]    bufData, maxFlips;
  logic [SW-1:0] chunkIdx;
  logic [1:0]    releaseBuf = '0;

  pp_chunk_engine #(.CHUNK_BYTES(CH), .MAX_PAGE_BYTES(MAXP), .TIMEOUT_CYCLES(TO)) dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .pageBytes(pageBytes),
    .flashData(flashData), .flashValid(flashValid), .flashReady(flashReady),
    .eccValid(eccValid), .eccStatus(eccStatus), .bufWe(bufWe), .bufSel(bufSel),
    .bufAddr(bufAddr), .bufData(bufData), .chunkReady(chunkReady), .chunkBuf(chunkBuf),
    .chunkIdx(chunkIdx), .releaseBuf(releaseBuf), .donePulse(donePulse),
    .maxFlips(maxFlips), .pageFail(pageFail), .pageTimeout(pageTimeout)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  int wrCount = 0;
  int wrBase = 0;
  int curId = 0;
  int relDelay = 0;
  int relCnt [2] = '{-1, -1};
  bit [1:0] heldModel = '0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dataOf(input int id, input int idx);
    return 8'((id * 37 + idx * 11 + (idx >> 3)) & 255);
  endfunction

  function automatic int cntOf(input int id, input int k);
    return (id * 29 + k * 53 + 5) % 128;
  endfunction

  // consumer model and write checker, away from the clock edges
  always @(negedge clk) begin
    #3;
    releaseBuf = '0;
    if (rstN) begin
      if (bufWe) begin
        int idx;
        idx = wrCount - wrBase;
        chk(bufSel == 1'((idx / CH) % 2), "R2 buffer select", int'(bufSel), (idx / CH) % 2);
        chk(bufAddr == CHL'(idx % CH), "R2 buffer address", int'(bufAddr), idx % CH);
        chk(bufData == dataOf(curId, idx), "R2 buffer data", int'(bufData), int'(dataOf(curId, idx)));
        chk(!heldModel[bufSel], "R3 write into owned buffer", 1, 0);
        wrCount++;
      end
      if (chunkReady) begin
        heldModel[chunkBuf] = 1'b1;
        relCnt[chunkBuf] = relDelay;
      end
      for (int b = 0; b < 2; b++) begin
        if (relCnt[b] >= 0) begin
          if (relCnt[b] == 0) begin
            releaseBuf[b] = 1'b1;
            heldModel[b] = 1'b0;
          end
          relCnt[b]--;
        end
      end
    end
  end

  task automatic runPage(input int id, input int bytes, input int eccDly, input int relDly,
                         input int failK, input int toK, input bit inject);
    int steps, mx, expRes;
    bit anyFail;
    steps = bytes / CH;
    mx = 0;
    anyFail = 0;
    relDelay = relDly;
    curId = id;
    wrBase = wrCount;
    @(negedge clk);
    pageBytes = PW'(bytes);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    if (steps == 0) begin
      #2;
      chk(donePulse == 1'b1, "R1 zero-step page completes next cycle", int'(donePulse), 1);
      chk(maxFlips == 8'd0, "R1 zero-step result", int'(maxFlips), 0);
    end else begin
      for (int k = 0; k < steps; k++) begin
        int idx;
        while (1) begin
          idx = wrCount - wrBase;
          if (idx >= (k + 1) * CH) break;
          flashValid = ((cyc + idx) % 4) != 1;
          flashData = dataOf(id, idx);
          if (inject && idx == 3) begin
            eccValid = 1'b1;
            eccStatus = 16'h0004 | (16'd127 << 3);
            startPulse = 1'b1;
            pageBytes = PW'(MAXP);
          end else begin
            eccValid = 1'b0;
            startPulse = 1'b0;
          end
          @(negedge clk);
        end
        flashValid = 1'b0;
        eccValid = 1'b0;
        startPulse = 1'b0;
        if (k == toK) begin
          repeat (TO - 1) @(negedge clk);
          #2;
          chk(donePulse == 1'b0, "R9 no abort on last allowed wait cycle", int'(donePulse), 0);
          @(negedge clk);
          #2;
          chk(donePulse == 1'b1, "R9 abort done after wait limit", int'(donePulse), 1);
          chk(pageTimeout == 1'b1, "R9 timeout flag", int'(pageTimeout), 1);
          break;
        end
        repeat (eccDly) @(negedge clk);
        eccValid = 1'b1;
        eccStatus = {6'h2A, 7'(cntOf(id, k)), (k == failK), 2'b11};
        if (k == failK) anyFail = 1;
        else if (cntOf(id, k) > mx) mx = cntOf(id, k);
        @(negedge clk);
        eccValid = 1'b0;
        #2;
        chk(chunkReady == 1'b1, "R7 ready pulse after capture", int'(chunkReady), 1);
        chk(chunkIdx == SW'(k), "R7 ready step index", int'(chunkIdx), k);
        chk(chunkBuf == 1'(k % 2), "R7 ready buffer index", int'(chunkBuf), k % 2);
        if (k == steps - 1) begin
          expRes = anyFail ? 255 : mx;
          chk(donePulse == 1'b1, $sformatf("R8 done after last step (R1 steps=%0d)", steps), int'(donePulse), 1);
          chk(maxFlips == 8'(expRes), inject ? "R10 R5 page result" : "R5 page result", int'(maxFlips), expRes);
          chk(pageFail == anyFail, "R6 fail flag", int'(pageFail), int'(anyFail));
          chk(pageTimeout == 1'b0, "R9 no timeout", int'(pageTimeout), 0);
          @(negedge clk);
          #2;
          chk(donePulse == 1'b0, "R8 done lasts one cycle", int'(donePulse), 0);
          chk(maxFlips == 8'(expRes), "R6 result held after done", int'(maxFlips), expRes);
        end else begin
          chk(flashReady == !heldModel[(k + 1) % 2],
              heldModel[(k + 1) % 2] ? "R3 stall on owned buffer" : "R4 next fill starts at once",
              int'(flashReady), int'(!heldModel[(k + 1) % 2]));
        end
      end
    end
    repeat (relDly + 4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(flashReady == 1'b0, "R11 reset flashReady", int'(flashReady), 0);
    chk(bufWe == 1'b0, "R11 reset bufWe", int'(bufWe), 0);
    chk(chunkReady == 1'b0, "R11 reset chunkReady", int'(chunkReady), 0);
    chk(donePulse == 1'b0, "R11 reset donePulse", int'(donePulse), 0);
    chk(maxFlips == 8'd0, "R11 reset maxFlips", int'(maxFlips), 0);
    chk(pageFail == 1'b0 && pageTimeout == 1'b0, "R11 reset flags", int'({pageFail, pageTimeout}), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    runPage(1, 16, 1, 2, -1, -1, 0);
    runPage(2, 64, 0, 20, -1, -1, 0);
    runPage(3, 20, 2, 0, -1, -1, 0);
    runPage(4, 32, 1, 3, 1, -1, 0);
    runPage(5, 5, 0, 0, -1, -1, 0);
    runPage(6, 24, TO - 1, 1, -1, -1, 1);
    runPage(7, 24, 1, 2, -1, 1, 0);
    runPage(8, 40, 3, 5, 2, -1, 0);
    runPage(9, 24, 0, 0, -1, -1, 0);
    for (int s = 1; s <= 8; s++) runPage(10 + s, s * CH, s % 3, (s * 5) % 11, -1, -1, 0);

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule